// File: doc/BRIEF.md
# Status LED controller with overrides

This block drives two board indicator LEDs from the low byte of a control register. Each LED has its own 4-bit selector that routes one of several board signals to the LED: a PHY LED line, a GPIO line, the RTC interrupt, a shared pin, an inverted UART line, or a constant off or on. A fixed priority of override conditions sits above each selector. LED1 yields to the watchdog counter and then to power-on reset. LED2 yields to a power blink while the enable input has not yet settled, and then to power-on reset.

When LED2 is left on its default selector code, it shows a boot-mode blink. The blink is fast when the board boots from SPI flash and slow when it boots from an SD card. All timing comes from the on-chip oscillator clock, which runs at about 24.18 MHz. One prescaler produces every blink rate. Both LED outputs are registered, so they change one cycle after their inputs and never glitch. An output value of 1 means the LED is lit.

Top module: `status_led_ctrl`

## Requirements
- R1: With no override active, LED1 follows `led_cfg[3:0]` as follows. Code 1 selects `phy_led[0]`, 2 selects `phy_led[1]`, 3 selects `phy_led[2]`, 4 selects `gpio7`, 5 selects `rtc_irq`, 6 gives 0, 7 gives 1, 8 selects `xio4`, 9 gives NOT `uart_rx`, and 10 gives NOT (`uart_rx` OR `uart_tx`).
- R2: With no override active, any other LED1 code (0 or 11 to 15) selects `gpio7`.
- R3: With no override active, LED2 follows `led_cfg[7:4]` with the R1 table, except that code 8 selects `xio5`, code 9 gives NOT `uart_tx`, and any code outside 1 to 10 selects the boot-mode blink.
- R4: Power-on reset is active while any of `pwr_en1`, `pwr_resin`, `pwr_good` or `por_done` is low. When `wd_en` is low and power-on reset is active, LED1 is 1.
- R5: While `wd_en` is high, LED1 shows `wd_cnt_b7`, whatever the power inputs and the selector are.
- R6: While the delayed enable is low, LED2 shows the power blink. Otherwise, LED2 is 1 while power-on reset is active.
- R7: The delayed enable goes high once `pwr_en1` has been high on `EN_DLY_CYCLES` consecutive clock edges. It goes low in the same cycle that `pwr_en1` goes low.
- R8: After reset, a phase counter advances by one every `TICK_CYCLES` clock edges. The fast, power and slow blinks are phase bits `FAST_BIT`, `PWR_BIT` and `SLOW_BIT`. The boot-mode blink is the slow blink when `boot_sd` is 1 and the fast blink when it is 0. An LED that shows a blink after clock edge k carries the phase value from edge k-1.
- R9: During reset both LEDs are 0. Otherwise, each LED takes the value computed from the inputs before a clock edge at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | On-chip oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| led_cfg | input | 8 | LED selectors: LED1 in [3:0], LED2 in [7:4] |
| phy_led | input | 3 | PHY LED lines 0 to 2 |
| gpio7 | input | 1 | GPIO line 7 |
| rtc_irq | input | 1 | RTC interrupt |
| xio4 | input | 1 | Shared pin routed to LED1 code 8 |
| xio5 | input | 1 | Shared pin routed to LED2 code 8 |
| uart_rx | input | 1 | Processor UART receive line |
| uart_tx | input | 1 | Processor UART transmit line |
| wd_cnt_b7 | input | 1 | Watchdog counter bit 7 |
| wd_en | input | 1 | Watchdog enabled |
| pwr_en1 | input | 1 | Power enable EN1 |
| pwr_resin | input | 1 | Reset-in status, low = asserted |
| pwr_good | input | 1 | All supplies good |
| por_done | input | 1 | Power-on sequence done |
| boot_sd | input | 1 | Boot source: 1 = SD card, 0 = SPI flash |
| led1 | output | 1 | LED1 drive, 1 = lit |
| led2 | output | 1 | LED2 drive, 1 = lit |

## Verification
A wrong selector decode or override order shows at the LED pins on the very next clock edge, because every path has exactly one register. A phase counter that has slipped moves the blink transitions by whole tick periods, so the error appears at the first blink edge after the slip. An enable-delay counter that counts wrongly makes LED2 leave the power blink too early or too late. It is caught in the exact cycle predicted from how long `pwr_en1` has been high, and a counter that holds its count after `pwr_en1` falls shows as LED2 missing the blink in the next cycle.

// File: rtl/led_pkg.sv
package led_pkg;
   localparam int SEL_W = 4;

   typedef enum logic [SEL_W-1:0] {
      LSEL_PHY0     = 4'd1,
      LSEL_PHY1     = 4'd2,
      LSEL_PHY2     = 4'd3,
      LSEL_GPIO     = 4'd4,
      LSEL_RTC      = 4'd5,
      LSEL_OFF      = 4'd6,
      LSEL_ON       = 4'd7,
      LSEL_XIO      = 4'd8,
      LSEL_INV_ONE  = 4'd9,
      LSEL_INV_BOTH = 4'd10
   } led_sel_e;

   typedef struct packed {
      logic [2:0] phy;
      logic       gpio7;
      logic       rtc;
      logic       uart_rx;
      logic       uart_tx;
   } led_common_t;
endpackage

// File: rtl/led_prescaler.sv
module led_prescaler #(
   parameter int TICK_CYCLES = 3022500,
   parameter int PHASE_W     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PHASE_W-1:0] phase
);
   localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("TICK_CYCLES must be at least 1");
   end

   logic [PW-1:0] pre;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre   <= '0;
         phase <= '0;
      end else if (pre == LAST) begin
         pre   <= '0;
         phase <= phase + 1'b1;
      end else begin
         pre <= pre + 1'b1;
      end
   end
endmodule

// File: rtl/en_delay.sv
module en_delay #(
   parameter int DLY_CYCLES = 2418000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_in,
   output logic en_dly
);
   localparam int CW = $clog2(DLY_CYCLES + 1);
   localparam logic [CW-1:0] FULL = CW'(DLY_CYCLES);

   if (DLY_CYCLES < 1) begin : g_bad_dly
      $error("DLY_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_in) cnt <= '0;
      else if (cnt != FULL) cnt <= cnt + 1'b1;
   end

   // falls in the same cycle as the raw enable
   assign en_dly = en_in && (cnt == FULL);
endmodule

// File: rtl/led_sel_mux.sv
module led_sel_mux
   import led_pkg::*;
#(
   parameter int LED_IDX = 0
) (
   input  logic [SEL_W-1:0] sel,
   input  led_common_t      com,
   input  logic             xio,
   input  logic             dflt,
   output logic             src
);
   logic inv_one;

   if (LED_IDX == 0) begin : g_led_first
      assign inv_one = ~com.uart_rx;
   end else if (LED_IDX == 1) begin : g_led_second
      assign inv_one = ~com.uart_tx;
   end else begin : g_bad_idx
      $error("LED_IDX must be 0 or 1");
      assign inv_one = 1'b0;
   end

   always_comb begin
      case (sel)
         LSEL_PHY0:     src = com.phy[0];
         LSEL_PHY1:     src = com.phy[1];
         LSEL_PHY2:     src = com.phy[2];
         LSEL_GPIO:     src = com.gpio7;
         LSEL_RTC:      src = com.rtc;
         LSEL_OFF:      src = 1'b0;
         LSEL_ON:       src = 1'b1;
         LSEL_XIO:      src = xio;
         LSEL_INV_ONE:  src = inv_one;
         LSEL_INV_BOTH: src = ~(com.uart_rx | com.uart_tx);
         default:       src = dflt;
      endcase
   end
endmodule

// File: rtl/status_led_ctrl.sv
module status_led_ctrl
   import led_pkg::*;
#(
   parameter int OSC_HZ        = 24180000,
   parameter int TICK_HZ       = 8,
   parameter int TICK_CYCLES   = OSC_HZ / TICK_HZ,
   parameter int PHASE_W       = 4,
   parameter int FAST_BIT      = 1,
   parameter int PWR_BIT       = 2,
   parameter int SLOW_BIT      = 3,
   parameter int EN_DLY_CYCLES = OSC_HZ / 10
) (
   input  logic       clk_osc,
   input  logic       rst_n,
   input  logic [7:0] led_cfg,
   input  logic [2:0] phy_led,
   input  logic       gpio7,
   input  logic       rtc_irq,
   input  logic       xio4,
   input  logic       xio5,
   input  logic       uart_rx,
   input  logic       uart_tx,
   input  logic       wd_cnt_b7,
   input  logic       wd_en,
   input  logic       pwr_en1,
   input  logic       pwr_resin,
   input  logic       pwr_good,
   input  logic       por_done,
   input  logic       boot_sd,
   output logic       led1,
   output logic       led2
);
   localparam int NLED = 2;

   if (FAST_BIT >= PHASE_W || PWR_BIT >= PHASE_W || SLOW_BIT >= PHASE_W) begin : g_bad_bits
      $error("blink bit index outside the phase counter");
   end
   if (FAST_BIT == SLOW_BIT || PWR_BIT == FAST_BIT || PWR_BIT == SLOW_BIT) begin : g_same_bits
      $error("blink rates must use distinct phase bits");
   end
   if (NLED * SEL_W != 8) begin : g_bad_cfg
      $error("selector width does not fit the config byte");
   end

   logic [PHASE_W-1:0] phase;
   logic               en1_dly;
   logic               por;
   logic               pwr_blink;
   logic               mode_blink;
   led_common_t        com;
   logic [NLED-1:0]    xio_v;
   logic [NLED-1:0]    dflt_v;
   logic [NLED-1:0]    src;

   led_prescaler #(
      .TICK_CYCLES(TICK_CYCLES),
      .PHASE_W    (PHASE_W)
   ) u_pre (
      .clk  (clk_osc),
      .rst_n(rst_n),
      .phase(phase)
   );

   en_delay #(
      .DLY_CYCLES(EN_DLY_CYCLES)
   ) u_dly (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .en_in (pwr_en1),
      .en_dly(en1_dly)
   );

   assign pwr_blink  = phase[PWR_BIT];
   assign mode_blink = boot_sd ? phase[SLOW_BIT] : phase[FAST_BIT];
   assign por        = ~(pwr_en1 & pwr_resin & pwr_good & por_done);

   assign com    = '{phy: phy_led, gpio7: gpio7, rtc: rtc_irq,
                     uart_rx: uart_rx, uart_tx: uart_tx};
   assign xio_v  = {xio5, xio4};
   assign dflt_v = {mode_blink, gpio7};

   for (genvar i = 0; i < NLED; i++) begin : g_mux
      led_sel_mux #(
         .LED_IDX(i)
      ) u_mux (
         .sel (led_cfg[i*SEL_W +: SEL_W]),
         .com (com),
         .xio (xio_v[i]),
         .dflt(dflt_v[i]),
         .src (src[i])
      );
   end

   always_ff @(posedge clk_osc) begin
      if (!rst_n) begin
         led1 <= 1'b0;
         led2 <= 1'b0;
      end else begin
         led1 <= wd_en    ? wd_cnt_b7 : (por | src[0]);
         led2 <= !en1_dly ? pwr_blink : (por | src[1]);
      end
   end
endmodule

// File: rtl/led_ctrl_chk.sv
module led_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] led_cfg,
   input logic       wd_en,
   input logic       wd_cnt_b7,
   input logic       pwr_en1,
   input logic       pwr_resin,
   input logic       pwr_good,
   input logic       por_done,
   input logic       en1_dly,
   input logic       pwr_blink,
   input logic       led1,
   input logic       led2
);
   logic por_in;
   assign por_in = !(pwr_en1 && pwr_resin && pwr_good && por_done);

   p_wdog_led1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_en |=> (led1 == $past(wd_cnt_b7)));

   p_por_led1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_en && por_in) |=> led1);

   p_off_led1_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_en && !por_in && led_cfg[3:0] == 4'd6) |=> !led1);

   p_pwr_blink_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en1_dly |=> (led2 == $past(pwr_blink)));

   p_por_led2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en1_dly && por_in) |=> led2);

   p_dly_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en1 |-> !en1_dly);
endmodule

bind status_led_ctrl led_ctrl_chk u_chk (
   .clk      (clk_osc),
   .rst_n    (rst_n),
   .led_cfg  (led_cfg),
   .wd_en    (wd_en),
   .wd_cnt_b7(wd_cnt_b7),
   .pwr_en1  (pwr_en1),
   .pwr_resin(pwr_resin),
   .pwr_good (pwr_good),
   .por_done (por_done),
   .en1_dly  (en1_dly),
   .pwr_blink(pwr_blink),
   .led1     (led1),
   .led2     (led2)
);

// File: tb/sim_status_led_ctrl.sv
module sim_status_led_ctrl;
   localparam int TICK = 4;
   localparam int DLY  = 5;
   localparam int FB = 1, PB = 2, SB = 3;

   typedef struct {
      bit    e1;
      bit    e2;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] led_cfg = 8'h00;
   logic [2:0] phy_led = 3'b000;
   logic       gpio7 = 0, rtc_irq = 0, xio4 = 0, xio5 = 0, uart_rx = 0, uart_tx = 0;
   logic       wd_cnt_b7 = 0, wd_en = 0;
   logic       pwr_en1 = 0, pwr_resin = 1, pwr_good = 1, por_done = 1, boot_sd = 0;
   logic       led1, led2;

   int   checks = 0;
   int   fails = 0;
   int   cyc = 0;
   int   hc = 0;
   bit   done = 0;
   string tag = "R9";
   exp_t q[$];

   always #10 clk = ~clk;

   status_led_ctrl #(
      .TICK_CYCLES  (TICK),
      .PHASE_W      (4),
      .FAST_BIT     (FB),
      .PWR_BIT      (PB),
      .SLOW_BIT     (SB),
      .EN_DLY_CYCLES(DLY)
   ) u0 (
      .clk_osc(clk), .rst_n(rst_n), .led_cfg(led_cfg), .phy_led(phy_led),
      .gpio7(gpio7), .rtc_irq(rtc_irq), .xio4(xio4), .xio5(xio5),
      .uart_rx(uart_rx), .uart_tx(uart_tx), .wd_cnt_b7(wd_cnt_b7),
      .wd_en(wd_en), .pwr_en1(pwr_en1), .pwr_resin(pwr_resin),
      .pwr_good(pwr_good), .por_done(por_done), .boot_sd(boot_sd),
      .led1(led1), .led2(led2)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else cyc <= cyc + 1;
   end

   function automatic bit phase_bit(int c, int b);
      return bit'(((c / TICK) >> b) & 1);
   endfunction

   function automatic bit sel_ref(int idx, logic [3:0] c, bit blink);
      case (c)
         4'd1: return phy_led[0];
         4'd2: return phy_led[1];
         4'd3: return phy_led[2];
         4'd4: return gpio7;
         4'd5: return rtc_irq;
         4'd6: return 1'b0;
         4'd7: return 1'b1;
         4'd8: return (idx == 0) ? xio4 : xio5;
         4'd9: return (idx == 0) ? ~uart_rx : ~uart_tx;
         4'd10: return ~(uart_rx | uart_tx);
         default: return (idx == 0) ? gpio7 : blink;
      endcase
   endfunction

   // driver: called just after a negedge with inputs set
   task automatic step();
      exp_t e;
      bit por, dly, mblink, pblink;
      por    = !(pwr_en1 && pwr_resin && pwr_good && por_done);
      dly    = pwr_en1 && (hc == DLY);
      pblink = phase_bit(cyc, PB);
      mblink = boot_sd ? phase_bit(cyc, SB) : phase_bit(cyc, FB);
      e.e1   = wd_en ? wd_cnt_b7 : (por ? 1'b1 : sel_ref(0, led_cfg[3:0], 1'b0));
      e.e2   = !dly ? pblink : (por ? 1'b1 : sel_ref(1, led_cfg[7:4], mblink));
      e.tag  = tag;
      hc     = pwr_en1 ? ((hc < DLY) ? hc + 1 : DLY) : 0;
      @(posedge clk);
      q.push_back(e);
      @(negedge clk);
   endtask

   task automatic steps(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // monitor
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (led1 !== e.e1 || led2 !== e.e2) begin
            fails++;
            $display("FAIL %s cyc=%0d actual led1=%b led2=%b expected led1=%b led2=%b",
                     e.tag, cyc, led1, led2, e.e1, e.e2);
         end
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   task automatic set_pattern(int v);
      phy_led = 3'(v);
      gpio7   = v[3];
      rtc_irq = v[4];
      xio4    = v[5];
      xio5    = v[6];
      uart_rx = v[7];
      uart_tx = v[8];
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (led1 !== 1'b0 || led2 !== 1'b0) begin
         fails++;
         $display("FAIL R9 reset actual led1=%b led2=%b expected 0 0", led1, led2);
      end
      rst_n = 1'b1;
      hc = 0;

      // power-up: EN1 low, POR on LED1, power blink on LED2
      tag = "R4 R6 power-up";
      led_cfg = 8'h66;
      steps(40);

      // EN1 rises: delay then selector (off)
      tag = "R7 enable delay rise";
      pwr_en1 = 1'b1;
      steps(12);

      // LED1 and LED2 selector sweeps
      for (int c = 0; c < 16; c++) begin
         for (int p = 0; p < 8; p++) begin
            tag = (c >= 1 && c <= 10) ? "R1 R3 R9 selector table" : "R2 R3 default codes";
            led_cfg = {4'(c), 4'(15 - c)};
            set_pattern(p * 53 + c * 29 + 7);
            boot_sd = p[0];
            step();
         end
      end

      // boot-mode blink on LED2
      tag = "R8 fast blink";
      led_cfg = 8'h06;
      boot_sd = 1'b0;
      steps(40);
      tag = "R8 slow blink";
      boot_sd = 1'b1;
      steps(70);

      // POR from each other source
      led_cfg = 8'h66;
      tag = "R4 R6 resin low";
      pwr_resin = 1'b0; steps(3); pwr_resin = 1'b1; steps(2);
      tag = "R4 R6 power-good low";
      pwr_good = 1'b0; steps(3); pwr_good = 1'b1; steps(2);
      tag = "R4 R6 por-done low";
      por_done = 1'b0; steps(3); por_done = 1'b1; steps(2);

      // watchdog override, also above POR
      tag = "R5 watchdog override";
      wd_en = 1'b1;
      for (int i = 0; i < 12; i++) begin
         wd_cnt_b7 = i[1];
         led_cfg   = (i % 3 == 0) ? 8'h77 : 8'h66;
         pwr_good  = (i > 6);
         step();
      end
      pwr_good = 1'b1;
      wd_en = 1'b0;
      steps(3);

      // EN1 drops: immediate power blink, then short high pulse below delay
      tag = "R7 enable drop and short pulse";
      led_cfg = 8'h77;
      pwr_en1 = 1'b0; steps(20);
      pwr_en1 = 1'b1; steps(DLY - 1);
      pwr_en1 = 1'b0; steps(4);
      pwr_en1 = 1'b1; steps(DLY + 6);

      while (q.size() > 0) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end
endmodule